// File: doc/BRIEF.md
# Wiper Register Command Engine

This engine interprets commands for a two-channel, 64-position digital potentiometer. A bus front end (not part of this block) recognises the start and stop of a frame, checks the device address and hands over the received bytes. Each frame carries one instruction byte, optionally followed by data bytes. Every channel has one volatile 6-bit wiper register that sets the tap. It also has four 6-bit storage registers that stand in for nonvolatile memory.

The engine reads and writes the wiper and storage registers. It copies between them for one channel or for both channels at once, and steps the wiper up or down one position at a time. Any change to the storage registers takes effect only when the frame closes. The engine then reports busy for a parameterised number of clock cycles to model the programming time. While busy is high, new frames are refused. After reset each wiper takes the reset content of storage slot 0 of its own channel.

Top module: `wiper_cmd_engine`

## Requirements
- R1: After reset, wiper n equals the reset value of storage slot 0 of channel n, busy is 0 and rd_data is 0.
- R2: Instruction byte layout: bits [7:4] opcode, bit 3 must be 0, bit 2 channel, bits [1:0] storage slot. With opcode 1010, each data byte writes its bits [5:0] into the selected wiper in the cycle after the byte is presented.
- R3: Opcode 1001 (wiper) and opcode 1011 (storage slot) place the selected 6-bit value on rd_data, zero-extended to 8 bits, in the cycle after the instruction byte.
- R4: With opcode 1100, bits [5:0] of the last data byte are stored into the selected slot only at frame stop. A frame that ends before any data byte changes nothing and does not raise busy.
- R5: Opcode 1101 copies the selected slot into its channel's wiper. Opcode 0001 copies slot [1:0] of every channel into that channel's wiper. Both copies take effect in the cycle after the instruction byte.
- R6: At frame stop, opcode 1110 copies the selected channel's wiper into the selected slot. At frame stop, opcode 0001's counterpart 1000 does the same for every channel.
- R7: With opcode 0010, each data byte moves the selected wiper one step: up if bit 0 is 1, down if it is 0. The wiper saturates at 0 and 63.
- R8: A stop that commits storage raises busy for exactly BUSY_CYC cycles. During that time, frames are ignored and the wipers hold.
- R9: An instruction byte with bit 3 set or an unlisted opcode is ignored together with the rest of its frame.
- R10: Frames that touch only wipers or reads leave busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| frm_start | input | 1 | one-cycle pulse: an addressed frame begins |
| byte_vld | input | 1 | one-cycle pulse: byte_dat holds a received byte |
| byte_dat | input | 8 | received byte |
| frm_stop | input | 1 | one-cycle pulse: frame ends |
| busy | output | 1 | storage programming in progress |
| rd_data | output | 8 | value returned by the last read command |
| wiper_code | output | 12 | wiper codes, channel 0 in bits [5:0] |

## Verification
The wiper codes, busy and rd_data are registered, so a wrong decode or a wrong phase shows up one cycle after the byte that caused it. A storage register that is corrupted stays hidden until a later read or copy brings it out. For this reason the sequence reads back every slot it writes, and it copies storage into the wipers. A busy count that is off by one appears at the end of the programming window. A frame that leaks through while busy is high appears as a moving wiper.

// File: rtl/wce_pkg.sv
package wce_pkg;
  typedef enum logic [3:0] {
    OP_GDR2W = 4'b0001,
    OP_STEP  = 4'b0010,
    OP_GW2DR = 4'b1000,
    OP_RDW   = 4'b1001,
    OP_WRW   = 4'b1010,
    OP_RDDR  = 4'b1011,
    OP_WRDR  = 4'b1100,
    OP_DR2W  = 4'b1101,
    OP_W2DR  = 4'b1110
  } op_e;

  typedef struct packed {
    logic       ok;
    op_e        op;
    logic       pot;
    logic [1:0] slot;
  } instr_t;

  typedef enum logic [1:0] {PH_IDLE, PH_INSTR, PH_DATA, PH_SKIP} phase_e;
endpackage

// File: rtl/wce_decode.sv
module wce_decode
  import wce_pkg::*;
(
  input  logic [7:0] ibyte,
  output instr_t     ins
);
  always_comb begin
    ins.op   = op_e'(ibyte[7:4]);
    ins.pot  = ibyte[2];
    ins.slot = ibyte[1:0];
    case (ibyte[7:4])
      4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
      4'b1011, 4'b1100, 4'b1101, 4'b1110: ins.ok = ~ibyte[3];
      default:                            ins.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/wce_sat_step.sv
module wce_sat_step #(
  parameter int WW = 6
) (
  input  logic [WW-1:0] cur,
  input  logic          up,
  output logic [WW-1:0] nxt
);
  localparam logic [WW-1:0] TOP = {WW{1'b1}};
  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
    else    nxt = (cur == '0)  ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/wce_busy.sv
module wce_busy #(
  parameter int CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (kick)            cnt_d = CW'(CYC);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != 0);
endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
  import wce_pkg::*;
#(
  parameter int WW       = 6,
  parameter int NDR      = 4,
  parameter int BUSY_CYC = 250000,
  parameter logic [2*NDR*WW-1:0] DR_RST =
    {6'd0, 6'd63, 6'd5, 6'd50, 6'd40, 6'd30, 6'd20, 6'd10}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_start,
  input  logic            byte_vld,
  input  logic [7:0]      byte_dat,
  input  logic            frm_stop,
  output logic            busy,
  output logic [7:0]      rd_data,
  output logic [2*WW-1:0] wiper_code
);
  localparam int NPOT = 2;
  localparam int DW   = 8;

  phase_e        phase_q, phase_d;
  instr_t        ins_q, ins_d, dec;
  logic          nv_q, nv_d, kick;
  logic [WW-1:0] dat_q, dat_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [WW-1:0] wcr_q [NPOT];
  logic [WW-1:0] wcr_d [NPOT];
  logic [WW-1:0] stp   [NPOT];
  logic [WW-1:0] dr_q  [NPOT][NDR];
  logic [WW-1:0] dr_d  [NPOT][NDR];
  logic          ev;

  wce_decode u_dec (.ibyte(byte_dat), .ins(dec));

  wce_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    wce_sat_step #(.WW(WW)) u_step (
      .cur(wcr_q[p]), .up(byte_dat[0]), .nxt(stp[p])
    );
    assign wiper_code[p*WW +: WW] = wcr_q[p];
  end

  assign ev = frm_start | frm_stop | byte_vld;

  always_comb begin
    phase_d = phase_q;
    ins_d   = ins_q;
    nv_d    = nv_q;
    dat_d   = dat_q;
    rd_d    = rd_q;
    wcr_d   = wcr_q;
    dr_d    = dr_q;
    kick    = 1'b0;
    if (frm_stop) begin
      phase_d = PH_IDLE;
      nv_d    = 1'b0;
      if (nv_q) begin
        kick = 1'b1;
        case (ins_q.op)
          OP_WRDR: dr_d[ins_q.pot][ins_q.slot] = dat_q;
          OP_W2DR: dr_d[ins_q.pot][ins_q.slot] = wcr_q[ins_q.pot];
          OP_GW2DR:
            for (int p = 0; p < NPOT; p++) dr_d[p][ins_q.slot] = wcr_q[p];
          default: ;
        endcase
      end
    end else if (frm_start) begin
      if (!busy) begin
        phase_d = PH_INSTR;
        nv_d    = 1'b0;
      end
    end else if (byte_vld) begin
      case (phase_q)
        PH_INSTR: begin
          ins_d   = dec;
          phase_d = dec.ok ? PH_DATA : PH_SKIP;
          if (dec.ok) begin
            case (dec.op)
              OP_RDW:  rd_d = {{(DW-WW){1'b0}}, wcr_q[dec.pot]};
              OP_RDDR: rd_d = {{(DW-WW){1'b0}}, dr_q[dec.pot][dec.slot]};
              OP_DR2W: wcr_d[dec.pot] = dr_q[dec.pot][dec.slot];
              OP_GDR2W:
                for (int p = 0; p < NPOT; p++) wcr_d[p] = dr_q[p][dec.slot];
              OP_W2DR, OP_GW2DR: nv_d = 1'b1;
              default: ;
            endcase
          end
        end
        PH_DATA: begin
          case (ins_q.op)
            OP_WRW:  wcr_d[ins_q.pot] = byte_dat[WW-1:0];
            OP_STEP: wcr_d[ins_q.pot] = stp[ins_q.pot];
            OP_WRDR: begin
              dat_d = byte_dat[WW-1:0];
              nv_d  = 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ins_q   <= '0;
      nv_q    <= 1'b0;
      dat_q   <= '0;
      rd_q    <= '0;
      for (int p = 0; p < NPOT; p++) begin
        wcr_q[p] <= DR_RST[(p*NDR)*WW +: WW];
        for (int r = 0; r < NDR; r++)
          dr_q[p][r] <= DR_RST[(p*NDR+r)*WW +: WW];
      end
    end else if (ev) begin
      phase_q <= phase_d;
      ins_q   <= ins_d;
      nv_q    <= nv_d;
      dat_q   <= dat_d;
      rd_q    <= rd_d;
      wcr_q   <= wcr_d;
      dr_q    <= dr_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/wce_chk.sv
module wce_chk #(
  parameter int WW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frm_start,
  input logic            frm_stop,
  input logic            busy,
  input logic [7:0]      rd_data,
  input logic [2*WW-1:0] wiper_code
);
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_stop)); // R8
  AST_WIPER_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wiper_code)); // R8
  AST_START_KEEPS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> $stable(wiper_code)); // R9
  AST_STOP_KEEPS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stop |=> $stable(wiper_code)); // R4
  AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:WW] == '0); // R3
endmodule

bind wiper_cmd_engine wce_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_stop(frm_stop),
  .busy(busy), .rd_data(rd_data), .wiper_code(wiper_code)
);

// File: tb/sim_wiper_cmd_engine.sv
module sim_wiper_cmd_engine;
  localparam int PER  = 10;
  localparam int BUSY = 20;

  logic        clk, rst_n, frm_start, byte_vld, frm_stop;
  logic [7:0]  byte_dat;
  logic        busy;
  logic [7:0]  rd_data;
  logic [11:0] wiper_code;

  int errs = 0, chks = 0;
  string cur_req = "R1";
  bit started = 0;

  wiper_cmd_engine #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .frm_stop(frm_stop), .busy(busy),
    .rd_data(rd_data), .wiper_code(wiper_code)
  );

  initial clk = 0;
  always #(PER/2) clk = ~clk;

  // behavioural reference
  int m_w[2], m_d[2][4], m_cnt, m_ph, m_op, m_pot, m_slot, m_nv, m_dat, m_rd;
  int rst_tab[2][4] = '{'{10, 20, 30, 40}, '{50, 5, 63, 0}};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_w[p] = rst_tab[p][0];
        for (int r = 0; r < 4; r++) m_d[p][r] = rst_tab[p][r];
      end
      m_cnt = 0; m_ph = 0; m_nv = 0; m_dat = 0; m_rd = 0; m_op = 0;
      m_pot = 0; m_slot = 0;
    end else begin
      bit kick;
      int op, pot, slot;
      kick = 0;
      if (frm_stop) begin
        if (m_nv != 0) begin
          kick = 1;
          if (m_op == 12) m_d[m_pot][m_slot] = m_dat;
          if (m_op == 14) m_d[m_pot][m_slot] = m_w[m_pot];
          if (m_op == 8) for (int p = 0; p < 2; p++) m_d[p][m_slot] = m_w[p];
        end
        m_ph = 0; m_nv = 0;
      end else if (frm_start) begin
        if (m_cnt == 0) begin m_ph = 1; m_nv = 0; end
      end else if (byte_vld) begin
        if (m_ph == 1) begin
          op = byte_dat[7:4]; pot = byte_dat[2]; slot = byte_dat[1:0];
          m_op = op; m_pot = pot; m_slot = slot;
          if (!byte_dat[3] && (op inside {1, 2, 8, 9, 10, 11, 12, 13, 14})) begin
            m_ph = 2;
            if (op == 9)  m_rd = m_w[pot];
            if (op == 11) m_rd = m_d[pot][slot];
            if (op == 13) m_w[pot] = m_d[pot][slot];
            if (op == 1) for (int p = 0; p < 2; p++) m_w[p] = m_d[p][slot];
            if (op == 14 || op == 8) m_nv = 1;
          end else m_ph = 3;
        end else if (m_ph == 2) begin
          if (m_op == 10) m_w[m_pot] = byte_dat % 64;
          if (m_op == 12) begin m_dat = byte_dat % 64; m_nv = 1; end
          if (m_op == 2) begin
            if (byte_dat[0]) begin if (m_w[m_pot] < 63) m_w[m_pot]++; end
            else if (m_w[m_pot] > 0) m_w[m_pot]--;
          end
        end
      end
      if (kick) m_cnt = BUSY;
      else if (m_cnt > 0) m_cnt--;
      started = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk({cur_req, " wiper0"}, wiper_code[5:0], m_w[0]);
      chk({cur_req, " wiper1"}, wiper_code[11:6], m_w[1]);
      chk({cur_req, " busy"}, busy, m_cnt != 0);
      chk({cur_req, " rd_data"}, rd_data, m_rd);
    end
  end

  task automatic cmd(input logic [7:0] ins, input int nd,
                     input logic [7:0] d0, input logic [7:0] d1);
    frm_start = 1; @(negedge clk); frm_start = 0;
    byte_vld = 1; byte_dat = ins; @(negedge clk);
    if (nd > 0) begin byte_dat = d0; @(negedge clk); end
    if (nd > 1) begin byte_dat = d1; @(negedge clk); end
    byte_vld = 0;
    frm_stop = 1; @(negedge clk); frm_stop = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(PER * 100000);
    errs++; chks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; frm_start = 0; byte_vld = 0; frm_stop = 0; byte_dat = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset wiper0", wiper_code[5:0], 10);
    chk("R1 reset wiper1", wiper_code[11:6], 50);
    chk("R1 reset busy", busy, 0);
    rst_n = 1; @(negedge clk);
    chk("R1 rd_data", rd_data, 0);

    cur_req = "R2";
    cmd(8'b1010_0000, 1, 8'hFF, 0);
    chk("R2 wcr write low bits", wiper_code[5:0], 63);
    chk("R10 no busy after wiper write", busy, 0);

    cur_req = "R3";
    cmd(8'b1011_0110, 0, 0, 0);
    chk("R3 read slot", rd_data, 63);
    cmd(8'b1001_0000, 0, 0, 0);
    chk("R3 read wiper", rd_data, 63);

    cur_req = "R7";
    cmd(8'b0010_0000, 2, 8'h01, 8'h01);
    chk("R7 saturate top", wiper_code[5:0], 63);
    cmd(8'b0010_0000, 2, 8'h00, 8'h00);
    chk("R7 step down", wiper_code[5:0], 61);
    cmd(8'b1010_0100, 1, 8'd1, 0);
    cmd(8'b0010_0100, 2, 8'h00, 8'h00);
    chk("R7 saturate bottom", wiper_code[11:6], 0);

    cur_req = "R5";
    cmd(8'b1101_0100, 0, 0, 0);
    chk("R5 slot to wiper", wiper_code[11:6], 50);
    cmd(8'b0001_0001, 0, 0, 0);
    chk("R5 global wiper0", wiper_code[5:0], 20);
    chk("R5 global wiper1", wiper_code[11:6], 5);
    chk("R10 no busy after copy", busy, 0);

    cur_req = "R4";
    cmd(8'b1100_0011, 1, 8'd33, 0);
    chk("R4 busy after commit", busy, 1);
    wait_idle();
    cmd(8'b1011_0011, 0, 0, 0);
    chk("R4 stored value", rd_data, 33);
    cmd(8'b1100_0010, 0, 0, 0);
    chk("R4 no data no busy", busy, 0);
    cmd(8'b1011_0010, 0, 0, 0);
    chk("R4 discarded write", rd_data, 30);

    cur_req = "R6";
    cmd(8'b1110_0111, 0, 0, 0);
    wait_idle();
    cmd(8'b1011_0111, 0, 0, 0);
    chk("R6 wiper to slot", rd_data, 5);
    cmd(8'b1010_0000, 1, 8'd7, 0);
    cmd(8'b1000_0001, 0, 0, 0);
    wait_idle();
    cmd(8'b1010_0000, 1, 8'd9, 0);
    cmd(8'b0001_0001, 0, 0, 0);
    chk("R6 global store pot0", wiper_code[5:0], 7);
    chk("R6 global store pot1", wiper_code[11:6], 5);

    cur_req = "R8";
    cmd(8'b1110_0000, 0, 0, 0);
    cmd(8'b1010_0000, 1, 8'd40, 0);
    chk("R8 frame ignored while busy", wiper_code[5:0], 7);
    wait_idle();
    cmd(8'b1110_0000, 0, 0, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R8 busy length", n, BUSY);

    cur_req = "R9";
    cmd(8'b0011_0000, 1, 8'd5, 0);
    chk("R9 unknown opcode", wiper_code[5:0], 7);
    cmd(8'b1010_1000, 1, 8'd5, 0);
    chk("R9 bit3 set", wiper_code[5:0], 7);
    chk("R9 no busy", busy, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule